// File: doc/BRIEF.md
# Stage-Budget Operation Scheduler with Refresh Insertion

This block sits between a source of primitive operation codes and an execution port that always accepts one issue slot per cycle. Each operation carries a stage depth. The scheduler keeps a running count of the stages issued since the last refresh pass. When the next operation would take that count past a programmable interval, it inserts a refresh pass first. Long operations are cut into chunks so that no stretch between refreshes goes over the interval.

A production flag makes the scheduler refuse arbitrary-unitary operations. Unknown codes and illegal lengths are also dropped with an error pulse. A separate request input asks for a refresh at the next batch boundary, for the case where a round has exceeded its budget. The input handshake is valid/ready. Ready falls in any cycle where the slot is taken by a refresh or by a continuation chunk.

Top module: `refresh_sched`

## Requirements
- R1: After reset, issue_valid_o, refresh_o, error_o, issue_op_o, issue_stages_o and depth_o are all zero, and in_ready_o is high.
- R2: Opcodes use 3 bits: 0 shift, 1 phase, 2 Fourier, 3 field add, 4 field multiply, 5 arbitrary unitary. Stage depths are shift = in_len_i (1 or 2), phase 1, field add 1, field multiply 3. An operation accepted at a clock edge appears on the issue port just after that edge. depth_o then holds the stage count since the last refresh.
- R3: The effective interval M is interval_i clamped to the range 8..12.
- R4: If an operation of depth 3 or less would push the count past M, a refresh slot is issued instead (refresh_o=1, issue_stages_o=0, depth_o=0). The operation stays on the input and issues in the next slot. depth_o never exceeds 12.
- R5: Fourier (length 12..32) and unitary operations are split. Each chunk fills the count up to M, a refresh follows, and the remainder continues in the same way. The last chunk leaves depth_o equal to its stage count.
- R6: With prod_i high, a unitary opcode is consumed, error_o pulses in the next cycle, and nothing is issued. With prod_i low, a unitary with length 1..63 is issued and split under R5.
- R7: Codes 6 and 7, a shift length other than 1 or 2, a Fourier length outside 12..32, and a unitary length of 0 are consumed with an error pulse. No issue follows and depth_o is unchanged.
- R8: A pulse on flush_req_i causes one refresh slot. It waits for any split operation to finish, and it comes before the next input is accepted.
- R9: in_ready_o is low in every cycle whose slot is taken by a refresh or a continuation chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Operation present |
| in_ready_o | output | 1 | Operation accepted this cycle |
| in_code_i | input | 3 | Operation code |
| in_len_i | input | 6 | Stage length for shift, Fourier and unitary |
| interval_i | input | 4 | Refresh interval setting |
| prod_i | input | 1 | Production mode, refuses unitary |
| flush_req_i | input | 1 | Request a batch-boundary refresh |
| issue_valid_o | output | 1 | Issue slot used |
| issue_op_o | output | 3 | Issued operation code (0 on refresh) |
| issue_stages_o | output | 6 | Stages issued in this slot |
| refresh_o | output | 1 | Slot is a refresh pass |
| error_o | output | 1 | Operation dropped |
| depth_o | output | 6 | Stages since last refresh |

## Verification
in_ready_o is combinational, so the bench checks it in the same cycle that the inputs are driven. The issue port, error_o and depth_o are registered, so each is due exactly one clock edge after the decision that produced it. The bench drives the inputs after a falling edge and compares ready 1 ns later. It then compares every registered output at the next falling edge against the slot its model predicted for that edge. Split operations and pending flushes are followed slot by slot, so a refresh that comes one cycle early or late shows up as a mismatch.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;
  localparam int OP_W = 3;
  typedef enum logic [OP_W-1:0] {
    OP_SHIFT   = 3'd0,
    OP_PHASE   = 3'd1,
    OP_FOURIER = 3'd2,
    OP_FADD    = 3'd3,
    OP_FMUL    = 3'd4,
    OP_UNITARY = 3'd5
  } op_e;
endpackage

// File: rtl/refresh_sched_decode.sv
module refresh_sched_decode
  import refresh_sched_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int F_MIN = 12,
  parameter int F_MAX = 32,
  parameter int MUL_D = 3
) (
  input  logic [OP_W-1:0]  code_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             prod_i,
  output logic             ok_o,
  output logic             split_o,
  output logic [LEN_W-1:0] depth_o
);
  always_comb begin
    ok_o    = 1'b0;
    split_o = 1'b0;
    depth_o = '0;
    case (code_i)
      OP_SHIFT: begin
        ok_o    = (len_i == LEN_W'(1)) || (len_i == LEN_W'(2));
        depth_o = len_i;
      end
      OP_PHASE, OP_FADD: begin
        ok_o    = 1'b1;
        depth_o = LEN_W'(1);
      end
      OP_FMUL: begin
        ok_o    = 1'b1;
        depth_o = LEN_W'(MUL_D);
      end
      OP_FOURIER: begin
        ok_o    = (len_i >= LEN_W'(F_MIN)) && (len_i <= LEN_W'(F_MAX));
        split_o = 1'b1;
        depth_o = len_i;
      end
      OP_UNITARY: begin
        ok_o    = !prod_i && (len_i != '0);
        split_o = 1'b1;
        depth_o = len_i;
      end
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/refresh_sched_interval.sv
module refresh_sched_interval #(
  parameter int INT_W = 4,
  parameter int LEN_W = 6,
  parameter int M_MIN = 8,
  parameter int M_MAX = 12
) (
  input  logic [INT_W-1:0] interval_i,
  output logic [LEN_W-1:0] m_o
);
  always_comb begin
    if (interval_i < INT_W'(M_MIN))      m_o = LEN_W'(M_MIN);
    else if (interval_i > INT_W'(M_MAX)) m_o = LEN_W'(M_MAX);
    else                                 m_o = LEN_W'(interval_i);
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int INT_W = 4,
  parameter int M_MIN = 8,
  parameter int M_MAX = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [OP_W-1:0]  in_code_i,
  input  logic [LEN_W-1:0] in_len_i,
  input  logic [INT_W-1:0] interval_i,
  input  logic             prod_i,
  input  logic             flush_req_i,
  output logic             issue_valid_o,
  output logic [OP_W-1:0]  issue_op_o,
  output logic [LEN_W-1:0] issue_stages_o,
  output logic             refresh_o,
  output logic             error_o,
  output logic [LEN_W-1:0] depth_o
);
  localparam int SUM_W = LEN_W + 1;

  logic             dec_ok, dec_split;
  logic [LEN_W-1:0] dec_depth, m;

  refresh_sched_decode #(.LEN_W(LEN_W)) u_dec (
    .code_i(in_code_i), .len_i(in_len_i), .prod_i(prod_i),
    .ok_o(dec_ok), .split_o(dec_split), .depth_o(dec_depth)
  );

  refresh_sched_interval #(.INT_W(INT_W), .LEN_W(LEN_W), .M_MIN(M_MIN), .M_MAX(M_MAX)) u_int (
    .interval_i(interval_i), .m_o(m)
  );

  logic [LEN_W-1:0] cnt_q, cnt_d, rem_q, rem_d;
  logic             hold_q, hold_d, flush_q, flush_clr;
  logic [OP_W-1:0]  hop_q, hop_d;
  logic             iv_d, ref_d, err_d;
  logic [OP_W-1:0]  op_d;
  logic [LEN_W-1:0] n_d;
  logic [SUM_W-1:0] sum;
  logic [LEN_W-1:0] room;
  logic             full;

  assign sum  = {1'b0, cnt_q} + {1'b0, dec_depth};
  assign full = (cnt_q >= m);
  assign room = m - cnt_q;

  always_comb begin
    cnt_d = cnt_q; rem_d = rem_q; hold_d = hold_q; hop_d = hop_q;
    flush_clr = 1'b0;
    iv_d = 1'b0; ref_d = 1'b0; err_d = 1'b0; op_d = '0; n_d = '0;
    in_ready_o = 1'b0;
    if (hold_q) begin
      iv_d = 1'b1;
      if (full) begin
        ref_d = 1'b1;
        cnt_d = '0;
      end else begin
        op_d = hop_q;
        n_d  = (rem_q <= room) ? rem_q : room;
        cnt_d = cnt_q + n_d;
        rem_d = rem_q - n_d;
        hold_d = (rem_q > room);
      end
    end else if (flush_q) begin
      iv_d = 1'b1; ref_d = 1'b1; cnt_d = '0; flush_clr = 1'b1;
    end else begin
      in_ready_o = 1'b1;
      if (in_valid_i) begin
        if (!dec_ok) begin
          err_d = 1'b1;
        end else if (sum <= {1'b0, m}) begin
          iv_d = 1'b1; op_d = in_code_i; n_d = dec_depth; cnt_d = sum[LEN_W-1:0];
        end else if (!dec_split || full) begin
          in_ready_o = 1'b0;  // op waits behind the refresh
          iv_d = 1'b1; ref_d = 1'b1; cnt_d = '0;
        end else begin
          iv_d = 1'b1; op_d = in_code_i; n_d = room; cnt_d = m;
          hold_d = 1'b1; hop_d = in_code_i; rem_d = dec_depth - room;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; rem_q <= '0; hold_q <= 1'b0; hop_q <= '0; flush_q <= 1'b0;
      issue_valid_o <= 1'b0; refresh_o <= 1'b0; error_o <= 1'b0;
      issue_op_o <= '0; issue_stages_o <= '0;
    end else begin
      cnt_q   <= cnt_d;
      rem_q   <= rem_d;
      hold_q  <= hold_d;
      hop_q   <= hop_d;
      flush_q <= (flush_q && !flush_clr) || flush_req_i;
      issue_valid_o  <= iv_d;
      refresh_o      <= ref_d;
      error_o        <= err_d;
      issue_op_o     <= op_d;
      issue_stages_o <= n_d;
    end
  end

  assign depth_o = cnt_q;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int LEN_W = 6,
  parameter int M_MAX = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [2:0]       in_code_i,
  input logic             prod_i,
  input logic             issue_valid_o,
  input logic             refresh_o,
  input logic [LEN_W-1:0] issue_stages_o,
  input logic             error_o,
  input logic [LEN_W-1:0] depth_o
);
  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= LEN_W'(M_MAX));
  a_r4_refresh_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |-> (depth_o == '0) && (issue_stages_o == '0) && issue_valid_o);
  a_r7_error_no_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !issue_valid_o && $stable(depth_o));
  a_r6_unitary_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && prod_i && in_code_i == 3'd5) |=> error_o);
  a_r9_stall_on_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |-> !$past(in_ready_o));
  a_r2_depth_accum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && !refresh_o) |-> depth_o == LEN_W'($past(depth_o) + issue_stages_o));
endmodule

bind refresh_sched refresh_sched_chk #(.LEN_W(LEN_W), .M_MAX(M_MAX)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .in_code_i(in_code_i), .prod_i(prod_i), .issue_valid_o(issue_valid_o),
  .refresh_o(refresh_o), .issue_stages_o(issue_stages_o), .error_o(error_o),
  .depth_o(depth_o)
);

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_code = '0;
  logic [5:0] in_len = '0;
  logic [3:0] interval = 4'd8;
  logic       prod = 1'b0;
  logic       flush_req = 1'b0;
  logic       iv, refr, err;
  logic [2:0] iop;
  logic [5:0] istg, depth;

  refresh_sched u_refresh_sched (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_code_i(in_code), .in_len_i(in_len), .interval_i(interval), .prod_i(prod),
    .flush_req_i(flush_req), .issue_valid_o(iv), .issue_op_o(iop),
    .issue_stages_o(istg), .refresh_o(refr), .error_o(err), .depth_o(depth)
  );

  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural model state
  int cnt = 0, rem = 0, hop = 0;
  bit hold = 0, fl = 0;
  int e_v, e_r, e_err, e_op, e_n;

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit legal(input int c, input int l, input bit p);
    case (c)
      0: return (l == 1 || l == 2);
      1, 3, 4: return 1;
      2: return (l >= 12 && l <= 32);
      5: return !p && l != 0;
      default: return 0;
    endcase
  endfunction

  function automatic int stages(input int c, input int l);
    if (c == 1 || c == 3) return 1;
    if (c == 4) return 3;
    return l;
  endfunction

  // one clock: returns whether the input was taken
  task automatic step(output bit took);
    int mm, d, n;
    bit rdy;
    #1;
    mm = (interval < 8) ? 8 : (interval > 12) ? 12 : int'(interval);
    e_v = 0; e_r = 0; e_err = 0; e_op = 0; e_n = 0; rdy = 0;
    if (hold) begin
      e_v = 1;
      if (cnt >= mm) begin e_r = 1; cnt = 0; end
      else begin
        n = (rem < mm - cnt) ? rem : mm - cnt;
        e_op = hop; e_n = n; cnt += n; rem -= n;
        if (rem == 0) hold = 0;
      end
    end else if (fl) begin
      e_v = 1; e_r = 1; cnt = 0; fl = 0;
    end else begin
      rdy = 1;
      if (in_valid) begin
        if (!legal(in_code, in_len, prod)) e_err = 1;
        else begin
          d = stages(in_code, in_len);
          if (cnt + d <= mm) begin e_v = 1; e_op = in_code; e_n = d; cnt += d; end
          else if (!(in_code == 2 || in_code == 5) || cnt >= mm) begin
            rdy = 0; e_v = 1; e_r = 1; cnt = 0;
          end else begin
            e_v = 1; e_op = in_code; e_n = mm - cnt; rem = d - (mm - cnt);
            cnt = mm; hold = 1; hop = in_code;
          end
        end
      end
    end
    if (flush_req) fl = 1;
    chk("ready", in_ready, rdy);
    took = rdy && in_valid;
    @(posedge clk);
    @(negedge clk);
    chk("issue_valid", iv, e_v);
    chk("refresh", refr, e_r);
    chk("error", err, e_err);
    chk("op", iop, e_op);
    chk("stages", istg, e_n);
    chk("depth", depth, cnt);
  endtask

  task automatic send(input int c, input int l, input bit f = 0);
    bit took;
    in_valid = 1; in_code = 3'(c); in_len = 6'(l); flush_req = f;
    for (int i = 0; i < 40; i++) begin
      step(took);
      flush_req = 0;
      if (took) break;
    end
    in_valid = 0;
  endtask

  task automatic idle(input int k, input bit f = 0);
    bit took;
    flush_req = f;
    for (int i = 0; i < k; i++) begin step(took); flush_req = 0; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    chk("valid", iv, 0); chk("refresh", refr, 0); chk("error", err, 0);
    chk("op", iop, 0); chk("stages", istg, 0); chk("depth", depth, 0);
    #1 chk("ready", in_ready, 1);
    @(negedge clk);

    tag = "R2"; interval = 4'd8;
    send(1, 0); send(3, 0); send(4, 0); send(0, 2); idle(1);
    tag = "R4"; send(4, 0); idle(1);            // 7+3>8: refresh then mul
    tag = "R7"; send(6, 0); send(7, 5); send(0, 0); send(0, 3);
    send(2, 11); send(2, 33); idle(1);
    tag = "R5"; send(2, 20); idle(4);           // 5 | R | 8 | R | 7
    tag = "R3"; interval = 4'd15;               // clamps to 12
    for (int i = 0; i < 6; i++) send(3, 0);
    idle(1);
    interval = 4'd2;                            // clamps to 8
    for (int i = 0; i < 9; i++) send(1, 0);
    idle(1);
    tag = "R6"; prod = 1; send(5, 4); send(5, 9); idle(1);
    prod = 0; send(5, 4); send(5, 40); idle(8);
    tag = "R8"; send(2, 12, 1); send(3, 0); idle(4);
    idle(1, 1); send(0, 1); idle(2);
    tag = "R9"; send(4, 0); send(4, 0); send(4, 0); send(2, 32); send(1, 0); idle(6);
    tag = "R2"; interval = 4'd10; send(0, 1); send(0, 2); send(4, 0); idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule